// File: doc/BRIEF.md
# Binary-Weight Bitplane Integer Accumulator

This block sums one tile of activations against binary weights, one column per weight bitplane. Each activation arrives as a signed integer significand that has already been shifted to a shared exponent. Every binary weight stands for either +1 or -1, so a column never multiplies. It either adds the significand to its running integer sum or subtracts it. All columns receive the same significand on the same cycle and each applies its own weight bit, so the bitplanes of a multi-bit weight are handled in parallel.

A tile is presented as a stream of valid terms. A start marker on the first term opens the tile and a last marker on the final term closes it. One cycle after the last term, the block raises a one-cycle done strobe and presents every column's final integer sum. Each sum is then held until the next tile closes. The accumulator width leaves room for a full tile of extreme-valued terms, so the sums are exact. Scaling by the bitplane factor, conversion back to floating point and merging of tiles happen outside this block.

Top module: `bitplane_acc_array`

## Requirements
- R1: While reset is asserted, `out_done` is 0 and every column sum in `out_sum` is 0.
- R2: On a valid term, a weight bit of 1 adds the significand to that column's sum and a weight bit of 0 subtracts it. Bit c of `in_wbit` belongs to column c.
- R3: A valid term with `in_start` set replaces the column's sum with that term alone, discarding whatever was accumulated before.
- R4: `out_done` is high for exactly the one cycle after a valid term carrying `in_last`, and it is low in every other cycle.
- R5: Cycles with `in_valid` low contribute nothing to the sums, whatever the other inputs carry. `out_sum` changes only in the cycle in which `out_done` rises.
- R6: Each column's sum depends only on the shared significands and its own weight bits. Column c occupies `out_sum[c*ACC_W +: ACC_W]` as a two's-complement value.
- R7: ACC_W equals SIG_W + 1 + clog2(ROWS). A tile of ROWS terms at the most negative or most positive significand, with either weight value, yields the exact sum and does not wrap.
- R8: A term carrying both `in_start` and `in_last` forms a one-term tile whose result is plus or minus that significand.
- R9: A start marker in the middle of an unfinished tile abandons the partial sum. The next result covers only the terms from the new start onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A term is presented this cycle |
| in_start | input | 1 | The term opens a new tile |
| in_last | input | 1 | The term closes the tile |
| in_sig | input | SIG_W | Signed pre-aligned significand shared by all columns |
| in_wbit | input | PLANES | One binary weight bit per column (1 = +1, 0 = -1) |
| out_done | output | 1 | One-cycle strobe: results are valid |
| out_sum | output | PLANES*ACC_W | Packed signed column sums, column 0 in the low bits |

## Verification
The checker watches the timing of the done strobe on every cycle: it must follow each closing term and nothing else. It also checks that results stay frozen between tile closings, that reset forces a quiet output, and that a one-term tile produces plus or minus its significand in column 0. The bench's scenarios are what show the arithmetic itself. They cover the exact add or subtract behaviour per column across all weight patterns and a sweep of significands, exact full-tile sums at the extremes of the range, that idle cycles carrying garbage are ignored, and that a restart mid-tile discards the partial sum.

// File: rtl/bitplane_acc_pkg.sv
package bitplane_acc_pkg;

  // Weight bit encoding: one means +1, zero means -1.
  typedef enum logic {
    OP_SUB = 1'b0,
    OP_ADD = 1'b1
  } term_op_e;

  // Headroom: one bit for negating the most negative significand,
  // clog2(rows) bits for summing a full tile.
  function automatic int acc_width(input int sig_w, input int rows);
    return sig_w + 1 + $clog2(rows);
  endfunction

endpackage

// File: rtl/bp_term_gen.sv
module bp_term_gen
  import bitplane_acc_pkg::*;
#(
  parameter int SIG_W = 11,
  parameter int ACC_W = 17
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             wbit,
  output logic [ACC_W-1:0] term
);

  localparam int EXT_W = ACC_W - SIG_W;

  logic [ACC_W-1:0] sig_ext;
  term_op_e         op;

  always_comb begin
    op      = term_op_e'(wbit);
    sig_ext = {{EXT_W{sig[SIG_W-1]}}, sig};
    if (op == OP_ADD) begin
      term = sig_ext;
    end else begin
      term = ~sig_ext + {{(ACC_W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/bp_seq.sv
module bp_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_start,
  input  logic in_last,
  output logic acc_en,
  output logic acc_clr,
  output logic res_cap,
  output logic done
);

  logic done_d;
  logic done_q;

  always_comb begin
    acc_en  = in_valid;
    acc_clr = in_valid & in_start;
    res_cap = in_valid & in_last;
    done_d  = res_cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/bp_column.sv
module bp_column #(
  parameter int ACC_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_clr,
  input  logic             res_cap,
  input  logic [ACC_W-1:0] term,
  output logic [ACC_W-1:0] result
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] res_q;

  always_comb begin
    if (acc_clr) begin
      acc_d = term;
    end else begin
      acc_d = acc_q + term;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_cap) begin
      res_q <= acc_d;
    end
  end

  assign result = res_q;

endmodule

// File: rtl/bitplane_acc_array.sv
module bitplane_acc_array
  import bitplane_acc_pkg::*;
#(
  parameter int SIG_W  = 11,
  parameter int ROWS   = 32,
  parameter int PLANES = 4,
  localparam int ACC_W = acc_width(SIG_W, ROWS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_start,
  input  logic                    in_last,
  input  logic [SIG_W-1:0]        in_sig,
  input  logic [PLANES-1:0]       in_wbit,
  output logic                    out_done,
  output logic [PLANES*ACC_W-1:0] out_sum
);

  logic acc_en;
  logic acc_clr;
  logic res_cap;

  bp_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_last  (in_last),
    .acc_en   (acc_en),
    .acc_clr  (acc_clr),
    .res_cap  (res_cap),
    .done     (out_done)
  );

  for (genvar c = 0; c < PLANES; c++) begin : g_col
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] result;

    bp_term_gen #(
      .SIG_W (SIG_W),
      .ACC_W (ACC_W)
    ) u_term (
      .sig  (in_sig),
      .wbit (in_wbit[c]),
      .term (term)
    );

    bp_column #(
      .ACC_W (ACC_W)
    ) u_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_en  (acc_en),
      .acc_clr (acc_clr),
      .res_cap (res_cap),
      .term    (term),
      .result  (result)
    );

    assign out_sum[c*ACC_W +: ACC_W] = result;
  end

endmodule

// File: rtl/bp_acc_checker.sv
module bp_acc_checker #(
  parameter int SIG_W  = 11,
  parameter int PLANES = 4,
  parameter int ACC_W  = 17
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_start,
  input logic                    in_last,
  input logic [SIG_W-1:0]        in_sig,
  input logic [PLANES-1:0]       in_wbit,
  input logic                    out_done,
  input logic [PLANES*ACC_W-1:0] out_sum
);

  logic             tile_end;
  logic             one_term;
  logic [ACC_W-1:0] one_term_val;

  always_comb begin
    tile_end     = in_valid & in_last;
    one_term     = in_valid & in_start & in_last;
    one_term_val = ACC_W'($signed(in_sig));
    if (!in_wbit[0]) begin
      one_term_val = -one_term_val;
    end
  end

  // R1: reset keeps the outputs quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_done && out_sum == '0));

  // R4: a closing term is followed by the strobe
  p_done_follows_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tile_end |=> out_done);

  // R4: the strobe has no other cause
  p_done_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(tile_end));

  // R5: results hold unless a tile just closed
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tile_end |=> $stable(out_sum));

  // R8: a one-term tile yields plus or minus its significand in column 0
  p_single_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
    one_term |=> out_sum[ACC_W-1:0] == $past(one_term_val));

endmodule

bind bitplane_acc_array bp_acc_checker #(
  .SIG_W  (SIG_W),
  .PLANES (PLANES),
  .ACC_W  (ACC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_start (in_start),
  .in_last  (in_last),
  .in_sig   (in_sig),
  .in_wbit  (in_wbit),
  .out_done (out_done),
  .out_sum  (out_sum)
);

// File: tb/tb_bitplane_acc_array.sv
module tb_bitplane_acc_array;

  localparam int SIG_W  = 4;
  localparam int ROWS   = 4;
  localparam int PLANES = 3;
  localparam int ACC_W  = SIG_W + 1 + $clog2(ROWS);

  logic                    clk;
  logic                    rst_n;
  logic                    in_valid;
  logic                    in_start;
  logic                    in_last;
  logic [SIG_W-1:0]        in_sig;
  logic [PLANES-1:0]       in_wbit;
  logic                    out_done;
  logic [PLANES*ACC_W-1:0] out_sum;

  int n_checks;
  int n_fails;
  int exp_sum [PLANES];
  bit finished;

  bitplane_acc_array #(
    .SIG_W  (SIG_W),
    .ROWS   (ROWS),
    .PLANES (PLANES)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_last  (in_last),
    .in_sig   (in_sig),
    .in_wbit  (in_wbit),
    .out_done (out_done),
    .out_sum  (out_sum)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int col_val(input int c);
    logic signed [ACC_W-1:0] v;
    v = out_sum[c*ACC_W +: ACC_W];
    return int'(v);
  endfunction

  task automatic check_int(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send(input bit st, input bit ls, input int sig, input int w);
    @(negedge clk);
    in_valid = 1'b1;
    in_start = st;
    in_last  = ls;
    in_sig   = SIG_W'(sig);
    in_wbit  = PLANES'(w);
    for (int c = 0; c < PLANES; c++) begin
      if (st) exp_sum[c] = 0;
      exp_sum[c] += ((w >> c) & 1) ? sig : -sig;
    end
  endtask

  task automatic idle_garbage(input int sig, input int w);
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b1;
    in_last  = 1'b1;
    in_sig   = SIG_W'(sig);
    in_wbit  = PLANES'(w);
  endtask

  task automatic finish_tile(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b0;
    in_last  = 1'b0;
    check_int("R4 done after last", int'(out_done), 1);
    for (int c = 0; c < PLANES; c++) check_int(req, col_val(c), exp_sum[c]);
    @(negedge clk);
    check_int("R4 done single cycle", int'(out_done), 0);
    for (int c = 0; c < PLANES; c++) check_int("R5 result held", col_val(c), exp_sum[c]);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_start = 1'b0;
    in_last  = 1'b0;
    in_sig   = '0;
    in_wbit  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_int("R1 done in reset", int'(out_done), 0);
    for (int c = 0; c < PLANES; c++) check_int("R1 sum in reset", col_val(c), 0);
    rst_n = 1'b1;

    // R2, R3, R6, R8, R5: sweep significands, weight patterns and lengths
    for (int base = 0; base < 16; base++) begin
      for (int w = 0; w < 8; w++) begin
        int len;
        len = (base % ROWS) + 1;
        for (int k = 0; k < len; k++) begin
          send(k == 0, k == len - 1, ((base + k * 5) % 16) - 8, (w + k) % 8);
          if ((base % 2 == 1) && k == 0 && len > 1) idle_garbage(7, 7 - w);
        end
        finish_tile("R2 R3 R6 column sum");
      end
    end

    // R7: full tiles at the range extremes
    for (int k = 0; k < ROWS; k++) send(k == 0, k == ROWS - 1, -8, 3'b010);
    finish_tile("R7 full tile most negative");
    for (int k = 0; k < ROWS; k++) send(k == 0, k == ROWS - 1, 7, 3'b101);
    finish_tile("R7 full tile most positive");

    // R9: restart mid-tile discards partial sum
    send(1'b1, 1'b0, 5, 3'b111);
    send(1'b0, 1'b0, 6, 3'b111);
    send(1'b1, 1'b0, -3, 3'b001);
    send(1'b0, 1'b1, 2, 3'b100);
    finish_tile("R9 restart mid tile");

    // R8: one-term tile with every weight pattern at an extreme value
    for (int w = 0; w < 8; w++) begin
      send(1'b1, 1'b1, -8, w);
      finish_tile("R8 single term tile");
    end

    report();
  end

endmodule